// File: doc/BRIEF.md
# Warp Divergence Mask Serializer

This block holds the lane-enable mask of one warp and walks it through two-way branches. When a branch starts, every lane of the warp gets a one-bit condition. The lanes that are currently enabled and whose condition is true run the first path. The lanes that are enabled and whose condition is false then run the second path. All lanes share one instruction stream, so the two paths never run at the same time. When the second path finishes, the mask goes back to the value it had when the branch began.

If every enabled lane agrees on the condition, only one path runs and nothing is serialized. Branches may nest inside each other up to a fixed depth. Each open branch keeps a frame on a small internal stack, and a branch-start that arrives when the stack is full is refused and flagged. After reset all lanes are enabled and no branch is open. The sequencer upstream pulses one strobe when a branch begins and another when the path now running ends, and it reads back the lane mask and which side of the branch is executing.

Top module: `simt_div_seq`

## Requirements
- R1: After reset, `active_mask_o` is all ones, `path_o` is 0 (outside any branch) and `stack_err_o` is 0.
- R2: When a branch starts with both some true and some false enabled lanes, the next cycle shows `active_mask_o` = predicate AND entry mask, with `path_o` = 1 (first path).
- R3: Ending the first path of a split branch makes `active_mask_o` = NOT predicate AND entry mask on the next cycle, with `path_o` = 2 (second path).
- R4: Ending the second path, or the only path of a uniform branch, restores the entry mask on the next cycle. `path_o` then returns to the enclosing branch's path code, or to 0 if no branch encloses it.
- R5: A branch whose predicate is true for every enabled lane leaves `active_mask_o` unchanged, sets `path_o` = 1, and closes after a single path-end.
- R6: A branch whose predicate is false for every enabled lane leaves `active_mask_o` unchanged, sets `path_o` = 2, and closes after a single path-end.
- R7: A branch started inside another branch uses the mask active at that moment as its entry mask. Up to DEPTH branches may be open at once.
- R8: A branch-start with DEPTH branches already open raises `stack_err_o` for exactly the next cycle and leaves the mask and path unchanged. `stack_err_o` is 0 in every other cycle.
- R9: A path-end strobe with no open branch has no effect: the mask stays all ones and `path_o` stays 0.
- R10: When branch-start and path-end arrive in the same cycle, the branch-start is served and the path-end is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_start_i | input | 1 | One-cycle strobe: a two-way branch begins |
| br_pred_i | input | LANES | Per-lane branch condition, sampled with `br_start_i` |
| path_end_i | input | 1 | One-cycle strobe: the path now executing has ended |
| active_mask_o | output | LANES | Lanes enabled for the current instruction |
| path_o | output | 2 | 0 outside any branch, 1 first path, 2 second path |
| stack_err_o | output | 1 | One-cycle pulse: branch-start refused because the stack is full |

## Verification
The assertions assume the strobes are single-cycle pulses that the sequencer raises only at its instruction boundaries. They also assume that a branch is never started while the enabled mask is empty, since the path chosen for an all-zero mask has no meaning to check. The stimulus keeps to these assumptions. It starts every branch from a mask of at least one lane, because the outer mask is all ones and each inner mask is a non-empty result of an outer split. It sweeps every outer and inner predicate of a four-lane, two-deep configuration. In each case it deliberately pushes past the full stack, then unwinds every open branch with path-end pulses.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    // Which side of the innermost open branch is executing.
    typedef enum logic [1:0] {
        PATH_NONE  = 2'd0,
        PATH_TAKEN = 2'd1,
        PATH_ELSE  = 2'd2
    } path_e;

    // Operation applied to the frame stack in one cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_SWAP = 2'd2,
        STK_POP  = 2'd3
    } stk_op_e;

endpackage

// File: rtl/simt_div_split.sv
// Splits the currently enabled lanes by the branch condition.
module simt_div_split #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] pred_i,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] taken_m_o,
    output logic [W-1:0] else_m_o,
    output logic         split_o,
    output logic         any_taken_o
);
    always_comb begin
        taken_m_o   = pred_i & cur_i;
        else_m_o    = ~pred_i & cur_i;
        any_taken_o = |taken_m_o;
        split_o     = any_taken_o && (|else_m_o);
    end
endmodule

// File: rtl/simt_div_stack.sv
// Fixed-depth stack of branch frames: entry mask, pending second-path mask,
// pending flag and current path code.
module simt_div_stack
    import simt_div_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op_i,
    input  logic [W-1:0]  push_entry_i,
    input  logic [W-1:0]  push_pend_i,
    input  logic          push_has_i,
    input  path_e         push_path_i,
    output logic [W-1:0]  top_entry_o,
    output logic [W-1:0]  top_pend_o,
    output logic          top_has_o,
    output path_e         under_path_o,
    output logic [LW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o
);
    typedef struct packed {
        logic [W-1:0] entry;
        logic [W-1:0] pend;
        logic         has;
        path_e        path;
    } frame_t;

    typedef struct packed {
        frame_t [DEPTH-1:0] mem;
        logic [LW-1:0]      lvl;
    } stk_t;

    stk_t   s_d, s_q;
    frame_t new_frame;
    int     wr_lvl;
    int     rd_lvl;

    always_comb begin
        new_frame.entry = push_entry_i;
        new_frame.pend  = push_pend_i;
        new_frame.has   = push_has_i;
        new_frame.path  = push_path_i;
    end

    always_comb begin
        s_d    = s_q;
        wr_lvl = int'(s_q.lvl);
        case (op_i)
            STK_PUSH: begin
                if (wr_lvl < int'(DEPTH)) begin
                    for (int i = 0; i < int'(DEPTH); i++) begin
                        if (i == wr_lvl) s_d.mem[i] = new_frame;
                    end
                    s_d.lvl = s_q.lvl + LW'(1);
                end
            end
            STK_SWAP: begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (i == wr_lvl - 1) begin
                        s_d.mem[i].has  = 1'b0;
                        s_d.mem[i].path = PATH_ELSE;
                    end
                end
            end
            STK_POP: begin
                if (wr_lvl > 0) s_d.lvl = s_q.lvl - LW'(1);
            end
            default: ;
        endcase
    end

    always_comb begin
        rd_lvl       = int'(s_q.lvl);
        top_entry_o  = '0;
        top_pend_o   = '0;
        top_has_o    = 1'b0;
        under_path_o = PATH_NONE;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (i == rd_lvl - 1) begin
                top_entry_o = s_q.mem[i].entry;
                top_pend_o  = s_q.mem[i].pend;
                top_has_o   = s_q.mem[i].has;
            end
            if (i == rd_lvl - 2) under_path_o = s_q.mem[i].path;
        end
        level_o = s_q.lvl;
        full_o  = (rd_lvl == int'(DEPTH));
        empty_o = (rd_lvl == 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/simt_div_seq.sv
// Top: serializes the two sides of each branch under complementary masks.
module simt_div_seq
    import simt_div_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_start_i,
    input  logic [LANES-1:0] br_pred_i,
    input  logic             path_end_i,
    output logic [LANES-1:0] active_mask_o,
    output logic [1:0]       path_o,
    output logic             stack_err_o
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LANES-1:0] active;
        path_e            path;
        logic             err;
    } seq_t;

    seq_t st_d, st_q;

    logic [LANES-1:0] taken_m, else_m;
    logic             split, any_taken;

    stk_op_e          stk_op;
    logic [LANES-1:0] push_pend;
    logic             push_has;
    path_e            push_path;
    logic [LANES-1:0] top_entry, top_pend;
    logic             top_has;
    path_e            under_path;
    logic [LVL_W-1:0] stk_level;
    logic             stk_full, stk_empty;

    simt_div_split #(.W(LANES)) u_split (
        .pred_i      (br_pred_i),
        .cur_i       (st_q.active),
        .taken_m_o   (taken_m),
        .else_m_o    (else_m),
        .split_o     (split),
        .any_taken_o (any_taken)
    );

    simt_div_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (stk_op),
        .push_entry_i (st_q.active),
        .push_pend_i  (push_pend),
        .push_has_i   (push_has),
        .push_path_i  (push_path),
        .top_entry_o  (top_entry),
        .top_pend_o   (top_pend),
        .top_has_o    (top_has),
        .under_path_o (under_path),
        .level_o      (stk_level),
        .full_o       (stk_full),
        .empty_o      (stk_empty)
    );

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        stk_op    = STK_HOLD;
        push_pend = '0;
        push_has  = 1'b0;
        push_path = PATH_NONE;
        if (br_start_i) begin
            if (stk_full) begin
                st_d.err = 1'b1;
            end else begin
                stk_op = STK_PUSH;
                if (split) begin
                    st_d.active = taken_m;
                    push_pend   = else_m;
                    push_has    = 1'b1;
                    push_path   = PATH_TAKEN;
                end else if (any_taken) begin
                    push_path = PATH_TAKEN;
                end else begin
                    push_path = PATH_ELSE;
                end
                st_d.path = push_path;
            end
        end else if (path_end_i && !stk_empty) begin
            if (top_has) begin
                stk_op      = STK_SWAP;
                st_d.active = top_pend;
                st_d.path   = PATH_ELSE;
            end else begin
                stk_op      = STK_POP;
                st_d.active = top_entry;
                st_d.path   = under_path;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{active: '1, path: PATH_NONE, err: 1'b0};
        else        st_q <= st_d;
    end

    assign active_mask_o = st_q.active;
    assign path_o        = st_q.path;
    assign stack_err_o   = st_q.err;
endmodule

// File: rtl/simt_div_seq_chk.sv
module simt_div_seq_chk #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_start,
    input logic             path_end,
    input logic [LANES-1:0] active,
    input logic [1:0]       path,
    input logic             err,
    input logic [LW-1:0]    lvl
);
    // R2
    narrowing_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_start && (int'(lvl) < int'(DEPTH)) |=>
            ((active & ~$past(active)) == '0) && (path != 2'd0));

    // R8
    overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_start && (int'(lvl) == int'(DEPTH)) |=>
            err && $stable(active) && $stable(path));

    // R8
    no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_start |=> !err);

    // R9
    idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_end && !br_start && (lvl == '0) |=> $stable(active) && (path == 2'd0));

    // R4
    unwound_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0) |-> (&active) && (path == 2'd0));

    // R10
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_start && path_end && (int'(lvl) < int'(DEPTH)) |=>
            int'(lvl) == int'($past(lvl)) + 1);
endmodule

bind simt_div_seq simt_div_seq_chk #(.LANES(LANES), .DEPTH(DEPTH), .LW(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_start (br_start_i),
    .path_end (path_end_i),
    .active   (active_mask_o),
    .path     (path_o),
    .err      (stack_err_o),
    .lvl      (stk_level)
);

// File: tb/tb_simt_div_seq.sv
module tb_simt_div_seq;
    localparam int L = 4;
    localparam int D = 2;
    localparam logic [L-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bs = 1'b0;
    logic         pe = 1'b0;
    logic [L-1:0] pred = '0;
    logic [L-1:0] act;
    logic [1:0]   path;
    logic         err;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    // expectation model, built from the requirements
    logic [L-1:0] m_act;
    int           m_path;
    bit           m_err;
    int           m_lvl;
    logic [L-1:0] m_ent [D];
    logic [L-1:0] m_pend[D];
    bit           m_has [D];
    int           m_fp  [D];

    always #2 clk = ~clk;

    simt_div_seq #(.LANES(L), .DEPTH(D)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .br_start_i    (bs),
        .br_pred_i     (pred),
        .path_end_i    (pe),
        .active_mask_o (act),
        .path_o        (path),
        .stack_err_o   (err)
    );

    task automatic check(input string req, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    task automatic model(input bit b, input bit e, input logic [L-1:0] p);
        logic [L-1:0] t, f;
        m_err = 0;
        if (b) begin
            if (m_lvl == D) m_err = 1;
            else begin
                t = p & m_act;
                f = ~p & m_act;
                m_ent[m_lvl] = m_act;
                m_has[m_lvl] = 0;
                if (t != 0 && f != 0) begin
                    m_act = t; m_pend[m_lvl] = f; m_has[m_lvl] = 1; m_path = 1;
                end else if (t != 0) m_path = 1;
                else m_path = 2;
                m_fp[m_lvl] = m_path;
                m_lvl++;
            end
        end else if (e && m_lvl > 0) begin
            if (m_has[m_lvl-1]) begin
                m_act = m_pend[m_lvl-1]; m_has[m_lvl-1] = 0; m_fp[m_lvl-1] = 2; m_path = 2;
            end else begin
                m_act = m_ent[m_lvl-1];
                m_lvl--;
                m_path = (m_lvl > 0) ? m_fp[m_lvl-1] : 0;
            end
        end
    endtask

    task automatic step(input bit b, input bit e, input logic [L-1:0] p, input string req);
        @(negedge clk);
        bs = b; pe = e; pred = p;
        model(b, e, p);
        @(posedge clk);
        #1;
        bs = 0; pe = 0;
        check(req, "mask", int'(act), int'(m_act));
        check(req, "path", int'(path), m_path);
        check(req, "err", int'(err), int'(m_err));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        string tag;
        m_act = ALL; m_path = 0; m_err = 0; m_lvl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "mask", int'(act), int'(ALL));
        check("R1", "path", int'(path), 0);
        check("R1", "err", int'(err), 0);

        // R9 stray path end
        step(0, 1, '0, "R9");
        step(0, 1, 4'hA, "R9");

        for (int po = 0; po < 16; po++) begin
            for (int pi = 0; pi < 16; pi++) begin
                tag = (po == 0) ? "R6" : (po == 15) ? "R5" : "R2";
                step(1, 0, L'(po), tag);
                step(1, 0, L'(pi), "R7");
                step(1, 0, L'(pi ^ po), "R8");
                step(0, 0, '0, "R8");
                while (m_lvl > 0) begin
                    tag = m_has[m_lvl-1] ? "R3" : "R4";
                    step(0, 1, '0, tag);
                end
            end
        end

        // R10 simultaneous strobes
        step(1, 1, 4'b0011, "R10");
        step(1, 1, 4'b0001, "R10");
        while (m_lvl > 0) step(0, 1, '0, "R4");

        report();
        $finish;
    end
endmodule